// File: doc/BRIEF.md
# Torus Output Selector with Adaptive and Escape Virtual Channels

This unit decides where a packet header goes next inside one node of a two-dimensional torus. Each physical link carries four virtual channels. Two of them are adaptive: a packet may use them on any link that moves it closer to its destination. The other two are escape channels. They follow strict X-then-Y dimension order, and a dateline split of the channel pair keeps them free of deadlock on the wrap-around links.

A header is accepted with a valid/ready handshake. The header carries the destination coordinates and, for each dimension, a flag that says whether the packet has already crossed that dimension's wrap-around link. The node's own coordinates and a busy vector covering every (port, channel) pair are also inputs. Exactly eight cycles after acceptance, the unit evaluates the busy vector.
- If a free adaptive channel exists on a productive port, it picks one using a round-robin pointer.
- Otherwise it uses the escape channel allowed for the packet.
- If that escape channel is also busy, it holds the header and tries again every cycle.

A header addressed to the local node is sent to the ejection port. That choice never depends on channel status.

Top module: `adaptive_route_sel`

## Requirements
- R1: `req_ready_o` is high while no header is pending. A header is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` then stays low, and further requests are ignored, until the decision for that header has been delivered.
- R2: When a channel is available, `out_valid_o` rises for exactly one cycle on the 8th clock edge after the accepting edge.
- R3: Per dimension, the offset is (dst - local) mod RADIX, with RADIX = 8 by default. A nonzero offset of at most RADIX/2 is productive in the plus direction; a larger offset is productive in the minus direction. Port codes are: 0 = +X, 1 = -X, 2 = +Y, 3 = -Y, 4 = local ejection.
- R4: An adaptive grant uses VC 0 or VC 1, on a productive port only, and only on a pair whose busy bit was clear. The busy bit of pair (port p, VC v) is `vc_busy_i[p*4+v]`.
- R5: Adaptive pairs are numbered port*2+vc, giving 0 to 7. The grant goes to the first free productive pair at or after the round-robin pointer, searching cyclically. After an adaptive grant, the pointer moves to the granted index plus one, modulo 8. Other grants leave the pointer unchanged.
- R6: An escape channel is used only when every adaptive pair on every productive port is busy. The escape port is the X port when the X offset is nonzero, and the Y port otherwise.
- R7: On the escape port, the channel is VC 2 if the header's crossed flag for that dimension is 0, and VC 3 if it is 1.
- R8: If no adaptive pair and no permitted escape channel is free at evaluation time, the header is held. It is re-evaluated on every edge, and the decision appears on the edge after a channel frees.
- R9: A header whose destination equals the local node gets port 4 and VC 0 at the normal latency, whatever the busy vector holds.
- R10: After reset, `req_ready_o` = 1, `out_valid_o` = 0, and the round-robin pointer = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Header valid |
| req_ready_o | output | 1 | Unit idle, header can be taken |
| dst_x_i | input | 3 | Destination X coordinate |
| dst_y_i | input | 3 | Destination Y coordinate |
| crossed_x_i | input | 1 | Packet has crossed the X wrap link |
| crossed_y_i | input | 1 | Packet has crossed the Y wrap link |
| loc_x_i | input | 3 | This node's X coordinate |
| loc_y_i | input | 3 | This node's Y coordinate |
| vc_busy_i | input | 16 | Busy flag per (port, VC), bit port*4+vc |
| out_valid_o | output | 1 | One-cycle decision strobe |
| out_port_o | output | 3 | Selected output port |
| out_vc_o | output | 2 | Selected virtual channel |

## Verification
The hardest situation to reach is a header stalled in evaluation and then released. Every adaptive pair on both productive ports must be busy and the dateline-selected escape channel must also be busy. A single channel is then freed a few cycles after the nominal decision time. The stimulus builds this by issuing a two-dimensional header with a busy mask that covers exactly those pairs. While the header is stalled, the bench offers a competing request to confirm it is ignored. It then frees either an adaptive pair or the escape channel, which shows that re-evaluation still prefers the adaptive subset. A tied offset of RADIX/2 and a route that wraps from the highest coordinate cover the direction logic. The round-robin pointer is tracked across the whole vector table.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;
  localparam int NUM_DIR = 4;

  typedef enum logic [2:0] {
    PORT_XP  = 3'd0,
    PORT_XM  = 3'd1,
    PORT_YP  = 3'd2,
    PORT_YM  = 3'd3,
    PORT_EJ  = 3'd4
  } port_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } state_e;
endpackage

// File: rtl/route_dim_dir.sv
// Offset in one torus dimension: nonzero flag and shorter-ring direction.
module route_dim_dir #(
  parameter int RADIX = 8,
  parameter int CW    = $clog2(RADIX)
) (
  input  logic [CW-1:0] loc_i,
  input  logic [CW-1:0] dst_i,
  output logic          nz_o,
  output logic          minus_o
);
  localparam int DW = CW + 1;

  logic [DW-1:0] diff;

  always_comb begin
    if (dst_i >= loc_i) diff = DW'(dst_i) - DW'(loc_i);
    else                diff = DW'(dst_i) + DW'(RADIX) - DW'(loc_i);
    nz_o    = (diff != '0);
    minus_o = (diff > DW'(RADIX / 2));
  end
endmodule

// File: rtl/route_rr_pick.sv
// First set request at or after ptr_i, cyclic.
module route_rr_pick #(
  parameter int N  = 8,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic          gnt_valid_o,
  output logic [PW-1:0] gnt_idx_o
);
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % N;
      if (!gnt_valid_o && req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/route_escape_sel.sv
// Dimension-ordered escape choice with dateline VC split.
module route_escape_sel #(
  parameter int NUM_VC   = 4,
  parameter int ADAPT_VC = 2,
  parameter int VW       = $clog2(NUM_VC)
) (
  input  logic                  nz_x_i,
  input  logic                  minus_x_i,
  input  logic                  minus_y_i,
  input  logic                  crossed_x_i,
  input  logic                  crossed_y_i,
  input  logic [4*NUM_VC-1:0]   busy_i,
  output logic [2:0]            port_o,
  output logic [VW-1:0]         vc_o,
  output logic                  free_o
);
  import route_sel_pkg::*;

  always_comb begin
    logic crossed;
    if (nz_x_i) begin
      port_o  = minus_x_i ? PORT_XM : PORT_XP;
      crossed = crossed_x_i;
    end else begin
      port_o  = minus_y_i ? PORT_YM : PORT_YP;
      crossed = crossed_y_i;
    end
    vc_o   = VW'(ADAPT_VC) + VW'(crossed);
    free_o = !busy_i[int'(port_o[1:0]) * NUM_VC + int'(vc_o)];
  end
endmodule

// File: rtl/adaptive_route_sel.sv
module adaptive_route_sel #(
  parameter int RADIX    = 8,
  parameter int NUM_VC   = 4,
  parameter int ADAPT_VC = 2,
  parameter int LATENCY  = 8,
  localparam int CW      = $clog2(RADIX),
  localparam int VW      = $clog2(NUM_VC),
  localparam int NPORT   = 4,
  localparam int NPAIR   = NPORT * ADAPT_VC,
  localparam int PW      = $clog2(NPAIR),
  localparam int LCW     = $clog2(LATENCY + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [CW-1:0]           dst_x_i,
  input  logic [CW-1:0]           dst_y_i,
  input  logic                    crossed_x_i,
  input  logic                    crossed_y_i,
  input  logic [CW-1:0]           loc_x_i,
  input  logic [CW-1:0]           loc_y_i,
  input  logic [NPORT*NUM_VC-1:0] vc_busy_i,
  output logic                    out_valid_o,
  output logic [2:0]              out_port_o,
  output logic [VW-1:0]           out_vc_o
);
  import route_sel_pkg::*;

  state_e         st_q;
  logic [LCW-1:0] cnt_q;
  logic [PW-1:0]  ptr_q;
  logic [CW-1:0]  dst_x_q, dst_y_q, loc_x_q, loc_y_q;
  logic           cx_q, cy_q;

  logic accept;
  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  // Direction per dimension
  logic nz_x, minus_x, nz_y, minus_y;

  route_dim_dir #(.RADIX(RADIX), .CW(CW)) u_dir_x (
    .loc_i(loc_x_q), .dst_i(dst_x_q), .nz_o(nz_x), .minus_o(minus_x)
  );
  route_dim_dir #(.RADIX(RADIX), .CW(CW)) u_dir_y (
    .loc_i(loc_y_q), .dst_i(dst_y_q), .nz_o(nz_y), .minus_o(minus_y)
  );

  // Productive ports and adaptive request mask
  logic [NPORT-1:0] prod;
  assign prod[PORT_XP] = nz_x && !minus_x;
  assign prod[PORT_XM] = nz_x &&  minus_x;
  assign prod[PORT_YP] = nz_y && !minus_y;
  assign prod[PORT_YM] = nz_y &&  minus_y;

  logic [NPAIR-1:0] ad_req;
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar v = 0; v < ADAPT_VC; v++) begin : g_vc
      assign ad_req[p*ADAPT_VC+v] = prod[p] && !vc_busy_i[p*NUM_VC+v];
    end
  end

  logic          ad_valid;
  logic [PW-1:0] ad_idx;

  route_rr_pick #(.N(NPAIR), .PW(PW)) u_rr (
    .req_i(ad_req), .ptr_i(ptr_q), .gnt_valid_o(ad_valid), .gnt_idx_o(ad_idx)
  );

  logic [2:0]    esc_port;
  logic [VW-1:0] esc_vc;
  logic          esc_free;

  route_escape_sel #(.NUM_VC(NUM_VC), .ADAPT_VC(ADAPT_VC), .VW(VW)) u_esc (
    .nz_x_i(nz_x), .minus_x_i(minus_x), .minus_y_i(minus_y),
    .crossed_x_i(cx_q), .crossed_y_i(cy_q), .busy_i(vc_busy_i),
    .port_o(esc_port), .vc_o(esc_vc), .free_o(esc_free)
  );

  // Decision
  logic          eval, is_local;
  logic          dec_valid, dec_adapt;
  logic [2:0]    dec_port;
  logic [VW-1:0] dec_vc;

  assign eval     = (st_q == ST_WAIT) && (cnt_q == LCW'(LATENCY));
  assign is_local = !nz_x && !nz_y;

  always_comb begin
    dec_valid = 1'b1;
    dec_adapt = 1'b0;
    dec_port  = PORT_EJ;
    dec_vc    = '0;
    if (is_local) begin
      dec_port = PORT_EJ;
    end else if (ad_valid) begin
      dec_adapt = 1'b1;
      dec_port  = 3'(int'(ad_idx) / ADAPT_VC);
      dec_vc    = VW'(int'(ad_idx) % ADAPT_VC);
    end else if (esc_free) begin
      dec_port = esc_port;
      dec_vc   = esc_vc;
    end else begin
      dec_valid = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      ptr_q       <= '0;
      dst_x_q     <= '0;
      dst_y_q     <= '0;
      loc_x_q     <= '0;
      loc_y_q     <= '0;
      cx_q        <= 1'b0;
      cy_q        <= 1'b0;
      out_valid_o <= 1'b0;
      out_port_o  <= '0;
      out_vc_o    <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (accept) begin
        st_q    <= ST_WAIT;
        cnt_q   <= LCW'(1);
        dst_x_q <= dst_x_i;
        dst_y_q <= dst_y_i;
        loc_x_q <= loc_x_i;
        loc_y_q <= loc_y_i;
        cx_q    <= crossed_x_i;
        cy_q    <= crossed_y_i;
      end else if (st_q == ST_WAIT) begin
        if (!eval) begin
          cnt_q <= cnt_q + LCW'(1);
        end else if (dec_valid) begin
          st_q        <= ST_IDLE;
          out_valid_o <= 1'b1;
          out_port_o  <= dec_port;
          out_vc_o    <= dec_vc;
          if (dec_adapt) ptr_q <= PW'((int'(ad_idx) + 1) % NPAIR);
        end
      end
    end
  end
endmodule

// File: rtl/adaptive_route_sel_chk.sv
module adaptive_route_sel_chk #(
  parameter int NUM_VC  = 4,
  parameter int LATENCY = 8,
  parameter int VW      = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [4*NUM_VC-1:0] vc_busy_i,
  input logic              out_valid_o,
  input logic [2:0]        out_port_o,
  input logic [VW-1:0]     out_vc_o
);
  logic [15:0]         since_acc;
  logic [4*NUM_VC-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_acc <= '0;
      busy_q    <= '0;
    end else begin
      busy_q <= vc_busy_i;
      if (req_valid_i && req_ready_o) since_acc <= '0;
      else if (since_acc != 16'hFFFF) since_acc <= since_acc + 16'd1;
    end
  end

  p_min_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (since_acc >= 16'(LATENCY)));

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_ready_on_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> req_ready_o);

  p_free_channel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_port_o != 3'd4) |->
      !busy_q[int'(out_port_o[1:0]) * NUM_VC + int'(out_vc_o)]);

  p_eject_vc0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_port_o == 3'd4) |-> (out_vc_o == '0));

  p_port_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_port_o <= 3'd4));
endmodule

bind adaptive_route_sel adaptive_route_sel_chk #(
  .NUM_VC(NUM_VC), .LATENCY(LATENCY), .VW(VW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .vc_busy_i(vc_busy_i),
  .out_valid_o(out_valid_o), .out_port_o(out_port_o), .out_vc_o(out_vc_o)
);

// File: tb/tb_adaptive_route_sel.sv
module tb_adaptive_route_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  dst_x_i = '0, dst_y_i = '0, loc_x_i = '0, loc_y_i = '0;
  logic        crossed_x_i = 1'b0, crossed_y_i = 1'b0;
  logic [15:0] vc_busy_i = '0;
  logic        out_valid_o;
  logic [2:0]  out_port_o;
  logic [1:0]  out_vc_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  adaptive_route_sel dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .crossed_x_i(crossed_x_i), .crossed_y_i(crossed_y_i),
    .loc_x_i(loc_x_i), .loc_y_i(loc_y_i), .vc_busy_i(vc_busy_i),
    .out_valid_o(out_valid_o), .out_port_o(out_port_o), .out_vc_o(out_vc_o)
  );

  // {loc_x, loc_y, dst_x, dst_y, cx, cy, busy, exp_port, exp_vc}
  localparam int NV = 13;
  localparam logic [34:0] TBL [NV] = '{
    {3'd2,3'd2,3'd4,3'd2,1'b0,1'b0,16'h0000,3'd0,2'd0}, // R5 ptr 0 -> pair0
    {3'd2,3'd2,3'd4,3'd2,1'b0,1'b0,16'h0000,3'd0,2'd1}, // R5 ptr 1 -> pair1
    {3'd2,3'd2,3'd4,3'd2,1'b0,1'b0,16'h0000,3'd0,2'd0}, // R5 wrap search
    {3'd2,3'd2,3'd0,3'd5,1'b0,1'b0,16'h0000,3'd1,2'd0}, // R3 -X, +Y
    {3'd2,3'd2,3'd0,3'd5,1'b0,1'b0,16'h0030,3'd2,2'd0}, // R4 -X busy
    {3'd2,3'd2,3'd2,3'd7,1'b0,1'b0,16'h0000,3'd3,2'd0}, // R3 -Y
    {3'd2,3'd2,3'd6,3'd2,1'b0,1'b0,16'h0000,3'd0,2'd0}, // R3 tie -> +X
    {3'd2,3'd2,3'd4,3'd5,1'b0,1'b0,16'h0303,3'd0,2'd2}, // R6 R7 VC2
    {3'd2,3'd2,3'd4,3'd5,1'b1,1'b0,16'h0303,3'd0,2'd3}, // R7 VC3
    {3'd2,3'd2,3'd2,3'd5,1'b0,1'b1,16'h0300,3'd2,2'd3}, // R6 Y escape
    {3'd2,3'd2,3'd4,3'd2,1'b0,1'b0,16'hFFFC,3'd0,2'd1}, // R4 other ports ignored
    {3'd2,3'd2,3'd2,3'd2,1'b0,1'b0,16'hFFFF,3'd4,2'd0}, // R9 eject
    {3'd7,3'd0,3'd1,3'd0,1'b0,1'b0,16'h0000,3'd0,2'd0}  // R3 wrap from edge
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue header at negedge; accepted at next posedge. Returns after
  // the negedge that follows the 7th edge after acceptance.
  task automatic issue(input logic [2:0] lx, ly, dx, dy, input logic cx, cy,
                       input logic [15:0] busy);
    @(negedge clk_i);
    loc_x_i = lx; loc_y_i = ly; dst_x_i = dx; dst_y_i = dy;
    crossed_x_i = cx; crossed_y_i = cy; vc_busy_i = busy;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R1 ready low after accept", req_ready_o, 0);
    repeat (7) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R2 no early decision", out_valid_o, 0);
  endtask

  task automatic hold_case(input logic [15:0] release_busy, input int ep, input int ev,
                           input string tag);
    issue(3'd2, 3'd2, 3'd4, 3'd5, 1'b0, 1'b0, 16'h0307);
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R8 blocked no decision", out_valid_o, 0);
    // competing request while stalled must be ignored
    dst_x_i = 3'd2; dst_y_i = 3'd2; req_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R8 still held", out_valid_o, 0);
    chk(req_ready_o == 1'b0, "R1 ready low while held", req_ready_o, 0);
    req_valid_i = 1'b0;
    vc_busy_i = release_busy;
    @(negedge clk_i);
    chk(out_valid_o == 1'b1, {tag, " released decision"}, out_valid_o, 1);
    chk(out_port_o == 3'(ep), {tag, " port"}, out_port_o, ep);
    chk(out_vc_o == 2'(ev), {tag, " vc"}, out_vc_o, ev);
    chk(req_ready_o == 1'b1, "R1 ready after decision", req_ready_o, 1);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk_i);
        if (out_valid_o) seen = 1'b1;
      end
      chk(!seen, "R1 ignored request produced no decision", seen, 0);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 ready in reset", req_ready_o, 1);
    chk(out_valid_o == 1'b0, "R10 valid low in reset", out_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 ready after reset", req_ready_o, 1);

    for (int n = 0; n < NV; n++) begin
      logic [34:0] t;
      t = TBL[n];
      issue(t[34:32], t[31:29], t[28:26], t[25:23], t[22], t[21], t[20:5]);
      @(negedge clk_i);
      chk(out_valid_o == 1'b1, "R2 decision at latency", out_valid_o, 1);
      chk(out_port_o == t[4:2], "R3/R5/R6/R9 port", out_port_o, t[4:2]);
      chk(out_vc_o == t[1:0], "R4/R5/R7/R9 vc", out_vc_o, t[1:0]);
      @(negedge clk_i);
      chk(out_valid_o == 1'b0, "R2 single pulse", out_valid_o, 0);
    end

    // R8: release an adaptive pair -> adaptive preferred (R6)
    hold_case(16'h0306, 0, 0, "R8 R6 adaptive");
    // R8: release the escape channel -> escape VC2 (R7)
    hold_case(16'h0303, 0, 2, "R8 R7 escape");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule